// File: doc/BRIEF.md
# Branch-Loadable Instruction Address Counter

This block produces the 8-bit instruction address of a small processor. A counter stage steps by one under an active-low increment strobe and is cleared by an active-low zero strobe. A PC register copies the counter one clock after each step or clear. The address pins normally show the PC register. An active-high synchronous reset puts the whole block in its idle state.

A jump target arrives as two 4-bit transfers on the data bus, each qualified by a nibble-load strobe. The first transfer is the upper half of the target and the second is the lower half. When the second half is captured, three things happen on the same edge. The target appears on the address pins from its own holding register, the counter is seeded with it, and the overflow flag clears. The next increment continues counting from the target. One cycle after that increment the pins return to the PC register, which then holds target plus one. An external select bit can also force the holding register onto the pins at any time.

Top module: `pc_addr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears. Afterwards `addr` is 0x00 and `ovf` is 0.
- R2: If `zero_n` is sampled low at edge k, the counter becomes 0x00 and `ovf` becomes 0 at edge k. `addr` shows 0x00 after edge k+1.
- R3: If `inc_n` is sampled low at edge k (with `zero_n` high and no branch completing), the counter advances by exactly one at edge k. `addr` shows the new value after edge k+1 and keeps its old value after edge k.
- R4: An increment from 0xFF wraps the counter to 0x00 and sets `ovf` at the same edge.
- R5: Once set, `ovf` stays high through further increments and idle cycles. It clears only on a zero strobe, on a branch completion, or on `rst`.
- R6: With `nib_ld` high, the first bus nibble goes to bits 7:4 of the target and the second to bits 3:0. On the edge that takes the second nibble, `addr` shows the full target, the counter is seeded with it, and `ovf` clears.
- R7: After a branch, `addr` keeps showing the target until an increment. For an increment sampled at edge k, `addr` shows target+1 after edge k+1.
- R8: `sel_br` high drives the branch holding register onto `addr`, whatever the counter state.
- R9: With `nib_ld` low, the data bus is not taken in. Changing it alters neither the holding register nor `addr`.
- R10: A zero strobe wins over a nibble load and an increment in the same cycle. It also restarts nibble assembly, so the next nibble is again taken as the upper half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_n | input | 1 | Active-low clear-to-zero strobe |
| inc_n | input | 1 | Active-low increment strobe |
| nib_ld | input | 1 | Take one target nibble from the bus |
| sel_br | input | 1 | Force the branch holding register onto the address |
| bus_nib | input | 4 | Data bus nibble |
| addr | output | 8 | Instruction address |
| ovf | output | 1 | Sticky counter overflow flag |

## Verification
A vector walk drives plain single increments, back-to-back increments and idle gaps. These show the one-cycle lag between the counter and the pins, and they separate a missing lag from a doubled step. A branch to 0xFE followed by two increments crosses the wrap point. That run separates a wrong nibble order, a counter that is not seeded, and a flag that fails to stick or to clear. Directed cases then cover these points:
- a zero strobe in the same cycle as a nibble load, after a half-loaded target, which exposes assembly that does not restart;
- a branch completing while the flag is set;
- a mid-run synchronous reset.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
  typedef enum logic {
    SRC_PC = 1'b0,
    SRC_BR = 1'b1
  } addr_src_e;
endpackage

// File: rtl/pc_count_stage.sv
module pc_count_stage #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          seed,
  input  logic [AW-1:0] seed_val,
  output logic [AW-1:0] cnt,
  output logic          ovf
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic [AW:0] sum;
  assign sum = {1'b0, cnt} + {{AW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (seed) begin
      cnt <= seed_val;
      ovf <= 1'b0;
    end else if (step) begin
      cnt <= sum[AW-1:0];
      if (sum[AW]) ovf <= 1'b1;
    end
  end

  p_zero_clears_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !ovf));
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !seed) |=> cnt == AW'($past(cnt) + 1'b1));
  p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !seed && cnt == TOP) |=> (ovf && cnt == '0));
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr && !seed) |=> ovf);
  p_seed_loads_r6: assert property (@(posedge clk) disable iff (rst)
    (seed && !clr) |=> (cnt == $past(seed_val) && !ovf));
endmodule

// File: rtl/pc_hold_reg.sv
module pc_hold_reg #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_req,
  input  logic [AW-1:0] cnt,
  output logic [AW-1:0] pc_q,
  output logic          xfer_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      xfer_q <= xfer_req;
      if (xfer_q) pc_q <= cnt;
    end
  end

  p_pc_takes_count_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_q |=> pc_q == $past(cnt));
  p_pc_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !xfer_q |=> $stable(pc_q));
endmodule

// File: rtl/pc_branch_asm.sv
module pc_branch_asm #(
  parameter int AW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld,
  input  logic          view_clr,
  input  logic [NW-1:0] bus_nib,
  output logic [AW-1:0] breg,
  output logic [AW-1:0] seed_val,
  output logic          seed,
  output logic          view
);
  localparam int NIBS = AW / NW;
  localparam int PW   = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [PW-1:0] LAST = PW'(NIBS - 1);

  logic [PW-1:0] ptr;
  logic          bus_en;
  logic [NW-1:0] bus_gated;

  // bus is taken in only while loading; otherwise the input is disabled
  assign bus_en    = ld && !clr;
  assign bus_gated = bus_en ? bus_nib : '0;
  assign seed      = bus_en && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (bus_en) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar s = 0; s < NIBS; s++) begin : g_slot
    localparam int LSB = (NIBS - 1 - s) * NW;
    always_ff @(posedge clk) begin
      if (rst) begin
        breg[LSB +: NW] <= '0;
      end else if (bus_en && ptr == PW'(s)) begin
        breg[LSB +: NW] <= bus_gated;
      end
    end
    if (s == NIBS - 1) begin : g_tail
      assign seed_val[LSB +: NW] = bus_gated;
    end else begin : g_head
      assign seed_val[LSB +: NW] = breg[LSB +: NW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      view <= 1'b0;
    end else if (seed) begin
      view <= 1'b1;
    end else if (view_clr) begin
      view <= 1'b0;
    end
  end

  p_bus_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(breg));
  p_zero_restarts_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == '0 && $stable(breg)));
  p_view_on_seed_r6: assert property (@(posedge clk) disable iff (rst)
    seed |=> (view && breg == $past(seed_val)));
endmodule

// File: rtl/pc_addr_sel.sv
module pc_addr_sel
  import pc_unit_pkg::*;
#(
  parameter int AW = 8
) (
  input  addr_src_e     src,
  input  logic [AW-1:0] pc_q,
  input  logic [AW-1:0] breg,
  output logic [AW-1:0] addr
);
  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign addr[b] = (src == SRC_BR) ? breg[b] : pc_q[b];
  end
endmodule

// File: rtl/pc_addr_unit.sv
module pc_addr_unit
  import pc_unit_pkg::*;
#(
  parameter int AW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero_n,
  input  logic          inc_n,
  input  logic          nib_ld,
  input  logic          sel_br,
  input  logic [NW-1:0] bus_nib,
  output logic [AW-1:0] addr,
  output logic          ovf
);
  logic          clr, step, seed, view, xfer_q;
  logic [AW-1:0] cnt, pc_q, breg, seed_val;
  addr_src_e     src;

  assign clr  = !zero_n;
  assign step = !inc_n && zero_n;
  assign src  = (sel_br || view) ? SRC_BR : SRC_PC;

  pc_count_stage #(.AW(AW)) u_count (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .seed(seed),
    .seed_val(seed_val), .cnt(cnt), .ovf(ovf)
  );

  pc_hold_reg #(.AW(AW)) u_hold (
    .clk(clk), .rst(rst), .xfer_req(clr || (step && !seed)),
    .cnt(cnt), .pc_q(pc_q), .xfer_q(xfer_q)
  );

  pc_branch_asm #(.AW(AW), .NW(NW)) u_branch (
    .clk(clk), .rst(rst), .clr(clr), .ld(nib_ld), .view_clr(xfer_q),
    .bus_nib(bus_nib), .breg(breg), .seed_val(seed_val), .seed(seed),
    .view(view)
  );

  pc_addr_sel #(.AW(AW)) u_sel (
    .src(src), .pc_q(pc_q), .breg(breg), .addr(addr)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (addr == '0 && !ovf));
  p_force_branch_r8: assert property (@(posedge clk) disable iff (rst)
    sel_br |-> addr == breg);
endmodule

// File: tb/pc_addr_unit_bench.sv
module pc_addr_unit_bench;
  logic       clk = 1'b0;
  logic       rst, zero_n, inc_n, nib_ld, sel_br;
  logic [3:0] bus_nib;
  logic [7:0] addr;
  logic       ovf;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_addr_unit u_pc_addr_unit (
    .clk(clk), .rst(rst), .zero_n(zero_n), .inc_n(inc_n), .nib_ld(nib_ld),
    .sel_br(sel_br), .bus_nib(bus_nib), .addr(addr), .ovf(ovf)
  );

  // {zero_n, inc_n, nib_ld, sel_br, bus, expected addr, expected ovf}
  localparam int NV = 19;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,1'b0,4'h0,8'h00,1'b0}, // idle
    {1'b1,1'b0,1'b0,1'b0,4'h0,8'h00,1'b0}, // R3 inc, pins lag
    {1'b1,1'b1,1'b0,1'b0,4'h0,8'h01,1'b0}, // R3 shows +1
    {1'b1,1'b0,1'b0,1'b0,4'h0,8'h01,1'b0}, // R3 back-to-back
    {1'b1,1'b0,1'b0,1'b0,4'h0,8'h02,1'b0},
    {1'b1,1'b1,1'b0,1'b0,4'h0,8'h03,1'b0},
    {1'b1,1'b1,1'b1,1'b0,4'hF,8'h03,1'b0}, // R6 upper nibble
    {1'b1,1'b1,1'b0,1'b0,4'hA,8'h03,1'b0}, // R9 bus ignored
    {1'b1,1'b1,1'b1,1'b0,4'hE,8'hFE,1'b0}, // R6 target shown
    {1'b1,1'b1,1'b0,1'b0,4'h0,8'hFE,1'b0}, // R7 holds target
    {1'b1,1'b0,1'b0,1'b0,4'h0,8'hFE,1'b0}, // R7 inc from target
    {1'b1,1'b1,1'b0,1'b0,4'h0,8'hFF,1'b0}, // R7 target+1
    {1'b1,1'b0,1'b0,1'b0,4'h0,8'hFF,1'b1}, // R4 wrap sets flag
    {1'b1,1'b1,1'b0,1'b0,4'h0,8'h00,1'b1}, // R4 pins wrap
    {1'b1,1'b0,1'b0,1'b0,4'h0,8'h00,1'b1}, // R5 sticky
    {1'b1,1'b1,1'b0,1'b0,4'h0,8'h01,1'b1}, // R5 sticky idle
    {1'b1,1'b1,1'b0,1'b1,4'h0,8'hFE,1'b1}, // R8 forced branch path
    {1'b0,1'b1,1'b0,1'b0,4'h0,8'h01,1'b0}, // R2 flag clear, pins lag
    {1'b1,1'b1,1'b0,1'b0,4'h0,8'h00,1'b0}  // R2 zero shown
  };

  task automatic drive(input logic zn, input logic inn, input logic nl,
                       input logic sb, input logic [3:0] b);
    @(negedge clk);
    zero_n = zn; inc_n = inn; nib_ld = nl; sel_br = sb; bus_nib = b;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] ea, input logic eo);
    checks++;
    if (addr !== ea || ovf !== eo) begin
      errors++;
      $display("FAIL %s: addr=%h ovf=%b expected addr=%h ovf=%b",
               req, addr, ovf, ea, eo);
    end
  endtask

  initial begin
    rst = 1'b1; zero_n = 1'b1; inc_n = 1'b1; nib_ld = 1'b0;
    sel_br = 1'b0; bus_nib = 4'h0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", 8'h00, 1'b0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:9]);
      check($sformatf("vector %0d (R2-R9)", i), VEC[i][8:1], VEC[i][0]);
    end

    // R10: half-loaded target, then zero with a simultaneous nibble load
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h5);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 4'h7);
    check("R10 zero wins", 8'h00, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h3);
    check("R10 first nibble not final", 8'h00, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'hC);
    check("R10 assembly restarted", 8'h3C, 1'b0);

    // R5/R6: branch to FF, wrap, then a branch clears the flag
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'hF);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'hF);
    check("R6 target FF", 8'hFF, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
    check("R4 wrap from target", 8'hFF, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 4'h0);
    check("R4 pins 00", 8'h00, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h1);
    check("R5 flag kept mid-load", 8'h00, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'h2);
    check("R5 branch clears flag", 8'h12, 1'b0);

    // R1: synchronous reset mid-run
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid-run reset", 8'h00, 1'b0);
    @(negedge clk) rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule